// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a bit-serial stream of 8421 BCD digits into the matching Excess-3 stream. Each digit uses four consecutive clock periods and enters least-significant bit first. In every period the block emits one output bit, and that bit belongs to the input bit present in the same period. Across the four periods the output bits form the input digit plus three, also least-significant bit first.

The block is a Mealy machine with seven states held in three flip-flops. Each state records which of the four bit positions comes next and whether a carry from the serial addition of 3 is pending. The output bit is a combinational function of the present state and the present input. The next state is loaded on the rising clock edge. After the fourth bit the machine always returns to the start-of-digit state, so no carry passes from one digit into the next. Codes above 9 are not flagged. They are converted modulo 16.

States and transitions. Here x is the input bit, z the output bit and c the pending carry.

| State | Position | c | z | x=0 goes to | x=1 goes to |
|---|---|---|---|---|---|
| ST_B0 | 0 | 0 | not x | ST_B1_C0 | ST_B1_C1 |
| ST_B1_C0 | 1 | 0 | not x | ST_B2_C0 | ST_B2_C1 |
| ST_B1_C1 | 1 | 1 | x | ST_B2_C1 | ST_B2_C1 |
| ST_B2_C0 | 2 | 0 | x | ST_B3_C0 | ST_B3_C0 |
| ST_B2_C1 | 2 | 1 | not x | ST_B3_C0 | ST_B3_C1 |
| ST_B3_C0 | 3 | 0 | x | ST_B0 | ST_B0 |
| ST_B3_C1 | 3 | 1 | not x | ST_B0 | ST_B0 |

The unused three-bit code falls back to ST_B0.

Top module: `xs3_serial_conv`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the machine enters ST_B0. From there the first bit after reset is treated as bit 0 of a new digit: z = not x.
- R2: The output `z_out` is combinational from the state and `x_in`. Changing `x_in` within a clock period changes `z_out` in that same period, with no clock edge in between.
- R3: For every input digit d of 0 to 9, sent LSB first over four periods, the four output bits equal d+3, also LSB first. Output bit k appears in the same period as input bit k.
- R4: After the fourth bit of a digit the machine returns to ST_B0. A carry out of bit 3 is discarded, so codes 10 to 15 yield (d+3) mod 16 and the next digit is unaffected.
- R5: The time-ordered input bits 0,0,1,0,1,0,0,1 give the output bits 1,1,1,0,0,0,1,1.
- R6: Reset is synchronous. Raising `rst` mid-digit does not change the current state before the next rising edge, and the bit after that edge starts a new digit.
- R7: Only the seven named states are ever held. The eighth code of the state register is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset to ST_B0 |
| x_in | input | 1 | Serial BCD input, LSB first, one bit per clock |
| z_out | output | 1 | Serial Excess-3 output for the present input bit |

## Verification
The bench sends all sixteen four-bit codes back to back and compares every output bit against a model that adds 3 to an integer. This catches a carry that leaks across digits, which would corrupt the digit after one that ends with a carry, as well as a wrongly placed carry at bit 1 or bit 2. It toggles the input inside a single clock period to expose a registered output, which would lag by a cycle. It raises reset mid-digit in the state where bit 0 and bit 2 give opposite outputs for the same input: an asynchronous reset would flip the output at once, and a reset that fails to restart framing would misalign the next digit. The two-digit sequence from the requirements is also replayed.

// File: rtl/xs3_pkg.sv
`timescale 1ns/1ps
package xs3_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_B0    = 3'd0,
        ST_B1_C0 = 3'd1,
        ST_B1_C1 = 3'd2,
        ST_B2_C0 = 3'd3,
        ST_B2_C1 = 3'd4,
        ST_B3_C0 = 3'd5,
        ST_B3_C1 = 3'd6
    } xs3_state_e;

    // Bit position (0..3) the machine expects next in a given state.
    function automatic logic [1:0] bit_pos(input xs3_state_e s);
        logic [1:0] p;
        unique case (s)
            ST_B0:              p = 2'd0;
            ST_B1_C0, ST_B1_C1: p = 2'd1;
            ST_B2_C0, ST_B2_C1: p = 2'd2;
            ST_B3_C0, ST_B3_C1: p = 2'd3;
            default:            p = 2'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xs3_next_state.sv
`timescale 1ns/1ps
module xs3_next_state
    import xs3_pkg::*;
(
    input  xs3_state_e state_q,
    input  logic       x_in,
    output xs3_state_e state_d
);

    always_comb begin
        unique case (state_q)
            // bit 0: add 1, carry out equals x
            ST_B0:    state_d = x_in ? ST_B1_C1 : ST_B1_C0;
            // bit 1: add 1 plus carry
            ST_B1_C0: state_d = x_in ? ST_B2_C1 : ST_B2_C0;
            ST_B1_C1: state_d = ST_B2_C1;
            // bit 2: add only carry
            ST_B2_C0: state_d = ST_B3_C0;
            ST_B2_C1: state_d = x_in ? ST_B3_C1 : ST_B3_C0;
            // bit 3: carry out is dropped, framing restarts
            ST_B3_C0: state_d = ST_B0;
            ST_B3_C1: state_d = ST_B0;
            default:  state_d = ST_B0;
        endcase
    end

endmodule

// File: rtl/xs3_out_logic.sv
`timescale 1ns/1ps
module xs3_out_logic
    import xs3_pkg::*;
(
    input  xs3_state_e state_q,
    input  logic       x_in,
    output logic       z_out
);

    always_comb begin
        unique case (state_q)
            ST_B0:    z_out = ~x_in;   // x + 1
            ST_B1_C0: z_out = ~x_in;   // x + 1 + 0
            ST_B1_C1: z_out =  x_in;   // x + 1 + 1
            ST_B2_C0: z_out =  x_in;   // x + 0
            ST_B2_C1: z_out = ~x_in;   // x + 1
            ST_B3_C0: z_out =  x_in;
            ST_B3_C1: z_out = ~x_in;
            default:  z_out = ~x_in;   // treated as start state
        endcase
    end

endmodule

// File: rtl/xs3_serial_conv.sv
`timescale 1ns/1ps
module xs3_serial_conv
    import xs3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);

    xs3_state_e state_q;
    xs3_state_e state_d;

    xs3_next_state u_next (
        .state_q (state_q),
        .x_in    (x_in),
        .state_d (state_d)
    );

    xs3_out_logic u_out (
        .state_q (state_q),
        .x_in    (x_in),
        .z_out   (z_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_B0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/xs3_serial_conv_chk.sv
`timescale 1ns/1ps
module xs3_serial_conv_chk
    import xs3_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x_in,
    input logic       z_out,
    input xs3_state_e state_q
);

    // Independent bit-position counter, restarted by reset.
    logic [1:0] pos_q;
    always_ff @(posedge clk) begin
        if (rst) pos_q <= 2'd0;
        else     pos_q <= pos_q + 2'd1;
    end

    p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_q == ST_B0);

    p_start_output_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_B0) |-> (z_out == !x_in));

    p_bit_position_r3: assert property (@(posedge clk) disable iff (rst)
        bit_pos(state_q) == pos_q);

    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_B3_C0 || state_q == ST_B3_C1) |=> state_q == ST_B0);

    p_carry_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_B0 && !x_in) |=> state_q == ST_B1_C0);

    p_legal_state_r7: assert property (@(posedge clk) disable iff (rst)
        state_q != xs3_state_e'(3'd7));

endmodule

bind xs3_serial_conv xs3_serial_conv_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/xs3_serial_conv_tb.sv
`timescale 1ns/1ps
module xs3_serial_conv_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    xs3_serial_conv u_dut (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one bit mid-cycle and check the output before the next rising edge.
    task automatic drive_bit(input logic b, input logic exp, input string req);
        @(negedge clk);
        x_in = b;
        #1;
        chk(req, z_out, exp);
    endtask

    // Reference: integer add of 3, kept modulo 16, compared bit by bit.
    task automatic send_digit(input int d, input string req);
        logic [3:0] din;
        logic [3:0] dexp;
        din  = 4'(d);
        dexp = 4'((d + 3) % 16);
        for (int k = 0; k < 4; k++) begin
            drive_bit(din[k], dexp[k], req);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] seq_in;
        logic [7:0] seq_out;

        // R1: reset state held through rising edges; bit 0 behaviour z = not x
        repeat (3) @(negedge clk);
        x_in = 1'b0; #1; chk("R1 reset z x=0", z_out, 1'b1);
        x_in = 1'b1; #1; chk("R1 reset z x=1", z_out, 1'b0);
        @(posedge clk); #0.5; rst = 1'b0;

        // R1: first digit after reset converts from bit 0
        send_digit(5, "R1 first digit 5");

        // R2: output follows the input within one period (ST_B0: z = not x)
        @(negedge clk);
        x_in = 1'b0; #0.5; chk("R2 same-cycle x=0", z_out, 1'b1);
        x_in = 1'b1; #0.5; chk("R2 same-cycle x=1", z_out, 1'b0);
        x_in = 1'b0; #0.5; chk("R2 same-cycle x=0 again", z_out, 1'b1);
        // this period consumed bit 0 = 0 of digit 6: finish it
        drive_bit(1'b1, 1'b0, "R2 digit 6 bit1");   // 6+3=9=1001
        drive_bit(1'b1, 1'b0, "R2 digit 6 bit2");
        drive_bit(1'b0, 1'b1, "R2 digit 6 bit3");

        // R3 / R4: every four-bit code back to back
        for (int d = 0; d < 10; d++) send_digit(d, "R3 bcd digit");
        for (int d = 10; d < 16; d++) send_digit(d, "R4 code above 9 mod 16");
        // R4: digit after ones whose carry left bit 3
        send_digit(0, "R4 no carry leak after 15");
        send_digit(13, "R4 carry out of bit 3");
        send_digit(1, "R4 no carry leak after 13");
        send_digit(7, "R3 digit 7");
        send_digit(9, "R3 digit 9");

        // R5: fixed two-digit sequence
        seq_in  = 8'b0010_1001;
        seq_out = 8'b1110_0011;
        for (int i = 7; i >= 0; i--) begin
            drive_bit(seq_in[i], seq_out[i], "R5 sequence");
        end

        // R6: synchronous reset mid-digit. Bits 0,0 lead to bit-2 state, no carry, where z = x.
        drive_bit(1'b0, 1'b1, "R6 bit0");
        drive_bit(1'b0, 1'b1, "R6 bit1");
        @(negedge clk);
        rst = 1'b1; x_in = 1'b1; #1;
        chk("R6 reset waits for edge", z_out, 1'b1);
        @(posedge clk); #0.5; rst = 1'b0;
        send_digit(4, "R6 digit after mid reset");
        send_digit(8, "R6 framing after mid reset");

        // R7: long run across all states; legality also asserted in the checker
        for (int d = 0; d < 16; d++) send_digit(15 - d, "R7 descending codes");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule